// File: doc/BRIEF.md
# Fast-Interrupt Source Selector

This block picks one interrupt source out of a three-bank interrupt controller and routes it to a dedicated fast-interrupt output. It sits next to the controller and receives the raw source levels of all three banks: two wide banks of peripheral sources and a narrow base bank. It does not mask, prioritise or acknowledge anything itself.

Software programs a single control word. The low seven bits are a linear source index and bit 7 is the enable. The index space is laid out with the first wide bank at indices 0 to 31, the second wide bank at 32 to 63 and the base bank from 64 upwards. When enabled, the fast-interrupt output follows the level of the selected raw source with one register stage of delay. The normal interrupt path is untouched. A source routed here still raises its ordinary interrupt if it is enabled there, so software is expected to disable it on the normal path first.

Top module: `fiq_source_select`

## Requirements
- R1: While synchronous reset `rst_n` is low, the control word is cleared, so after reset `cfg_rdata` reads 0 and `fiq_o` is low.
- R2: A write (`cfg_we` high at a clock edge) stores `cfg_wdata[6:0]` as the source index and `cfg_wdata[7]` as the enable. Both read back on `cfg_rdata[6:0]` and `cfg_rdata[7]` after that edge.
- R3: `cfg_rdata` bits 31 down to 8 always read 0, whatever value was written to them.
- R4: With the enable set and an index from 0 to 31, `fiq_o` follows `src_bank_a[index]`.
- R5: With the enable set and an index from 32 to 63, `fiq_o` follows `src_bank_b[index-32]`.
- R6: With the enable set and an index from 64 to 71, `fiq_o` follows `src_base[index-64]`.
- R7: An index from 72 to 127 selects no source, and `fiq_o` stays low even with every source active.
- R8: With the enable clear, `fiq_o` is low at every edge after the one where the enable was seen clear, whatever the sources and the index are.
- R9: `fiq_o` is registered. Its value after a clock edge equals the enable AND the selected source level, both sampled just before that edge. A write and a source change therefore show up one edge later.
- R10: Without a write, the control word holds its value.
- R11: Sources other than the selected one have no effect on `fiq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read-back |
| src_bank_a | input | 32 | Raw levels of the first wide bank (indices 0 to 31) |
| src_bank_b | input | 32 | Raw levels of the second wide bank (indices 32 to 63) |
| src_base | input | 8 | Raw levels of the base bank (indices 64 to 71) |
| fiq_o | output | 1 | Registered fast-interrupt request |

## Verification
The hardest cases to reach from the ports are the edges of the index map. These are the bank boundaries at 31/32, 63/64 and 71/72, and the unused range up to 127. A wrong offset there still gives a plausible-looking output, so a plain walk through the bank-a sources would miss it. The stimulus programs those exact indices and drives the non-selected sources all high while the selected one is toggled. This exposes any mis-decoded neighbour. A long random phase follows, with mixed writes and source patterns, and every cycle is compared against a behavioural reference.

// File: rtl/fiqsel_pkg.sv
// Package: shared constants for the fast-interrupt source selector.
// Assumes a control word whose low IDX_W bits are the index and next bit the enable.
package fiqsel_pkg;
    localparam int unsigned IDX_W  = 7;
    localparam int unsigned DATA_W = 32;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
    } fiqsel_ctrl_t;
endpackage

// File: rtl/fiqsel_ctrl_reg.sv
// Control word storage: captures index and enable on a write, reads back
// zero-extended. Assumes synchronous active-low reset.
module fiqsel_ctrl_reg
    import fiqsel_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic          en,
    output logic [IW-1:0] idx,
    output logic [DW-1:0] rdata
);
    localparam int unsigned USED_W = IW + 1;

    // Hold the control word; only index and enable bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en  <= 1'b0;
            idx <= '0;
        end else if (we) begin
            en  <= wdata[IW];
            idx <= wdata[IW-1:0];
        end
    end

    // Read-back: unused upper bits are constant zero.
    always_comb begin
        rdata             = '0;
        rdata[USED_W-1:0] = {en, idx};
    end
endmodule

// File: rtl/fiqsel_src_mux.sv
// Index decoder: maps the linear index onto bank A, bank B, then the base bank.
// Indices past the last source match nothing. Purely combinational.
module fiqsel_src_mux #(
    parameter int unsigned IW     = 7,
    parameter int unsigned A_W    = 32,
    parameter int unsigned B_W    = 32,
    parameter int unsigned BASE_W = 8
) (
    input  logic [IW-1:0]     idx,
    input  logic [A_W-1:0]    bank_a,
    input  logic [B_W-1:0]    bank_b,
    input  logic [BASE_W-1:0] base,
    output logic              hit
);
    localparam int unsigned TOTAL = A_W + B_W + BASE_W;

    logic [TOTAL-1:0] flat;
    logic [TOTAL-1:0] match;

    // Concatenate in index order: bank A lowest, then bank B, then base.
    assign flat = {base, bank_b, bank_a};

    // One comparator per source position.
    for (genvar i = 0; i < TOTAL; i++) begin : g_pos
        assign match[i] = (idx == IW'(i)) & flat[i];
    end

    // At most one position can match; OR-reduce to the selected level.
    assign hit = |match;
endmodule

// File: rtl/fiqsel_out_stage.sv
// Output register: fast-interrupt request is the gated level delayed one cycle.
module fiqsel_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic hit,
    output logic fiq
);
    // Register the enable-gated selected level.
    always_ff @(posedge clk) begin
        if (!rst_n) fiq <= 1'b0;
        else        fiq <= en & hit;
    end
endmodule

// File: rtl/fiq_source_select.sv
// Top: fast-interrupt source selector. Routes one of the three banks' raw
// sources to fiq_o under a software index/enable word. Assumes sources are
// already synchronous to clk; the normal interrupt path is not touched.
module fiq_source_select
    import fiqsel_pkg::*;
#(
    parameter int unsigned DW     = DATA_W,
    parameter int unsigned IW     = IDX_W,
    parameter int unsigned A_W    = 32,
    parameter int unsigned B_W    = 32,
    parameter int unsigned BASE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [DW-1:0]     cfg_wdata,
    output logic [DW-1:0]     cfg_rdata,
    input  logic [A_W-1:0]    src_bank_a,
    input  logic [B_W-1:0]    src_bank_b,
    input  logic [BASE_W-1:0] src_base,
    output logic              fiq_o
);
    logic          sel_en;
    logic [IW-1:0] sel_idx;
    logic          sel_hit;

    fiqsel_ctrl_reg #(.DW(DW), .IW(IW)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .en    (sel_en),
        .idx   (sel_idx),
        .rdata (cfg_rdata)
    );

    fiqsel_src_mux #(.IW(IW), .A_W(A_W), .B_W(B_W), .BASE_W(BASE_W)) u_mux (
        .idx    (sel_idx),
        .bank_a (src_bank_a),
        .bank_b (src_bank_b),
        .base   (src_base),
        .hit    (sel_hit)
    );

    fiqsel_out_stage u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (sel_en),
        .hit   (sel_hit),
        .fiq   (fiq_o)
    );
endmodule

// File: rtl/fiqsel_checker.sv
// Checker: port-level properties of the selector, bound to the top module.
module fiqsel_checker #(
    parameter int unsigned DW     = 32,
    parameter int unsigned IW     = 7,
    parameter int unsigned A_W    = 32,
    parameter int unsigned B_W    = 32,
    parameter int unsigned BASE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [DW-1:0]     cfg_wdata,
    input logic [DW-1:0]     cfg_rdata,
    input logic [A_W-1:0]    src_bank_a,
    input logic              fiq_o
);
    localparam int unsigned TOTAL = A_W + B_W + BASE_W;

    logic          rd_en;
    logic [IW-1:0] rd_idx;
    logic          a_sel_low;

    assign rd_en  = cfg_rdata[IW];
    assign rd_idx = cfg_rdata[IW-1:0];

    // Selected bank-A level is low (only meaningful when index is in bank A).
    always_comb begin
        a_sel_low = 1'b0;
        for (int i = 0; i < A_W; i++)
            if (rd_idx == IW'(i)) a_sel_low = !src_bank_a[i];
    end

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[DW-1:IW+1] == '0); // R3
    AST_WRITE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg_rdata[IW:0] == $past(cfg_wdata[IW:0])); // R2
    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_rdata)); // R10
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !fiq_o); // R8
    AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_idx) >= TOTAL) |=> !fiq_o); // R7
    AST_BANK_A_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && int'(rd_idx) < A_W && a_sel_low) |=> !fiq_o); // R4
endmodule

bind fiq_source_select fiqsel_checker #(
    .DW(DW), .IW(IW), .A_W(A_W), .B_W(B_W), .BASE_W(BASE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .src_bank_a (src_bank_a),
    .fiq_o      (fiq_o)
);

// File: tb/fiq_source_select_tb.sv
// Bench: behavioural reference updated every rising edge, compared at every
// falling edge, plus directed checks at the index-map boundaries.
module fiq_source_select_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [31:0] src_bank_a = '0;
    logic [31:0] src_bank_b = '0;
    logic [7:0]  src_base = '0;
    logic        fiq_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit cmp_on = 1'b0;

    // Reference state
    int m_idx = 0;
    bit m_en = 1'b0;
    bit m_fiq = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    fiq_source_select u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .src_bank_a(src_bank_a), .src_bank_b(src_bank_b),
        .src_base(src_base), .fiq_o(fiq_o)
    );

    function automatic bit pick(int idx, logic [31:0] a, logic [31:0] b, logic [7:0] c);
        if (idx < 32) return a[idx];
        if (idx < 64) return b[idx-32];
        if (idx < 72) return c[idx-64];
        return 1'b0;
    endfunction

    function automatic string fiq_tag(int idx, bit en);
        if (!en)      return "R8 R9";
        if (idx < 32) return "R4 R9 R11";
        if (idx < 64) return "R5 R9 R11";
        if (idx < 72) return "R6 R9 R11";
        return "R7 R9";
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Reference model update at each rising edge.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            m_idx <= 0; m_en <= 1'b0; m_fiq <= 1'b0;
        end else begin
            m_fiq <= m_en && pick(m_idx, src_bank_a, src_bank_b, src_base);
            if (cfg_we) begin
                m_idx <= int'(cfg_wdata[6:0]);
                m_en  <= cfg_wdata[7];
            end
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            check(fiq_tag(m_idx, m_en), {31'd0, fiq_o}, {31'd0, m_fiq});
            check("R2 R10 R3", cfg_rdata, {24'd0, m_en, 7'(m_idx)});
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 20000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected<20000", cyc);
            finish_run();
        end
    end

    task automatic wr(logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        idle(3);
        check("R1", cfg_rdata, 32'd0);
        check("R1", {31'd0, fiq_o}, 32'd0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        idle(2);

        // R4 / R9: bank A index 5, one-cycle lag
        wr(32'h85);
        src_bank_a = 32'hFFFF_FFDF;       // everything except the selected source
        @(negedge clk);
        check("R11", {31'd0, fiq_o}, 32'd0);
        src_bank_a = 32'h0000_0020;
        @(negedge clk);
        check("R9", {31'd0, fiq_o}, 32'd1);
        src_bank_a = 32'h0;
        @(negedge clk);
        check("R9", {31'd0, fiq_o}, 32'd0);

        // Boundary 31 / 32 / 63 / 64 / 71 / 72 with neighbours high
        wr(32'h80 | 31);
        src_bank_a = 32'h8000_0000; idle(2);
        src_bank_a = '0; src_bank_b = 32'hFFFF_FFFF; idle(2);
        wr(32'h80 | 32);
        src_bank_b = 32'h0000_0001; src_bank_a = 32'hFFFF_FFFF; idle(2);
        src_bank_b = 32'hFFFF_FFFE; idle(2);
        wr(32'h80 | 63);
        src_bank_b = 32'h8000_0000; src_base = 8'hFF; src_bank_a = '0; idle(2);
        wr(32'h80 | 64);
        src_base = 8'h01; src_bank_b = 32'hFFFF_FFFF; idle(2);
        src_base = 8'hFE; idle(2);
        wr(32'h80 | 71);
        src_base = 8'h80; idle(2);
        src_base = 8'h7F; idle(2);

        // R7: unused index range with every source active
        src_bank_a = '1; src_bank_b = '1; src_base = '1;
        wr(32'h80 | 72); idle(3);
        check("R7", {31'd0, fiq_o}, 32'd0);
        wr(32'h80 | 127); idle(3);
        check("R7", {31'd0, fiq_o}, 32'd0);

        // R8: enable cleared with a valid index and active source
        wr(32'h80 | 10); idle(2);
        check("R4", {31'd0, fiq_o}, 32'd1);
        wr(32'h0A); idle(2);
        check("R8", {31'd0, fiq_o}, 32'd0);

        // R3: upper bits written as ones read zero
        wr(32'hFFFF_FF83);
        check("R3", cfg_rdata, 32'h0000_0083);
        check("R2", cfg_rdata[7:0], 8'h83);

        // Random phase
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            src_bank_a = $urandom; src_bank_b = $urandom; src_base = 8'($urandom);
            if (($urandom % 5) == 0) begin
                cfg_we = 1'b1; cfg_wdata = $urandom;
            end else begin
                cfg_we = 1'b0; cfg_wdata = $urandom;
            end
        end
        @(negedge clk);
        cfg_we = 1'b0;
        idle(3);
        finish_run();
    end
endmodule